// File: doc/BRIEF.md
# Attenuator Serial Programming Master

This block sits on the host side of a digitally stepped attenuator. It takes a 6-bit attenuation word and writes it to the attenuator's three-wire serial port, which has a clock, a data line and a latch-enable line. A request is a one-cycle `start` pulse while `ready` is high. The word is captured on that cycle and shifted out most significant bit first. Data is sampled by the attenuator on each rising serial-clock edge. After the last bit, a latch-enable pulse commits the word.

Every edge on the three lines is placed by a phase counter. Each phase is loaded with a cycle count that the parameters derive from the system clock period. Each count is rounded up, so the clock high time, clock low time, data setup, data hold, clock-low-to-latch setup, latch pulse width and the slowest permitted serial clock period are all met. The serial clock and latch idle low. While a transfer is in flight the block ignores new requests.

Top module: `atten_serial_master`

## Requirements
- R1: Each transfer presents exactly 6 bits on `ser_data`. They are sampled at rising edges of `ser_clk`, bit 5 of `word` first and bit 0 last.
- R2: `ser_clk` stays high for at least ceil(30 ns / Tclk) cycles and low for at least ceil(30 ns / Tclk) cycles before each rising edge.
- R3: `ser_data` is stable for at least ceil(10 ns / Tclk) cycles before each rising edge. It does not change for at least ceil(10 ns / Tclk) cycles after that edge, and it changes only while `ser_clk` is low.
- R4: `ser_latch` rises only after all 6 bits have been clocked, and only after `ser_clk` has been low for at least ceil(10 ns / Tclk) cycles. It is never high while `ser_clk` is high.
- R5: The `ser_latch` pulse is at least ceil(30 ns / Tclk) cycles wide.
- R6: Successive rising edges of `ser_clk` are at least ceil(100 ns / Tclk) cycles apart, which keeps the serial clock at or below 10 MHz.
- R7: `ready` drops in the cycle after an accepted `start`. It stays low until the cycle in which `ser_latch` returns low, and it is high in that same cycle.
- R8: A `start` pulse while `ready` is low is ignored. The word in flight and the transfer length are unchanged.
- R9: After reset, and whenever `ready` is high, `ser_clk` and `ser_latch` are low and `ready` is 1.
- R10: A transfer keeps `ready` low for exactly 6*(H+L)+S+W cycles, where:
  - H is the larger of the high and hold counts;
  - L is the largest of the low count, the setup count and the period count minus H;
  - S is the latch setup count;
  - W is the latch width count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request, accepted while `ready` is high |
| word | input | 6 | Attenuation word, captured with `start` |
| ready | output | 1 | High when idle and able to accept a request |
| ser_clk | output | 1 | Serial clock to the attenuator, idles low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_latch | output | 1 | Latch-enable pulse after the last bit |

## Verification
The bench sweeps all 64 attenuation words, so every bit pattern is seen. Alternating bits, long runs of equal bits and the all-zero and all-one words each show whether the bit order is right and whether data edges keep clear of the clock edges. Every fourth word has a conflicting request injected mid-transfer, which separates a block that ignores busy requests from one that restarts or reloads. Each observed phase length is compared with ceilings and totals that the bench works out itself from the 8 ns period. Because the period limit stretches the low phase beyond its own minimum, a design that drops the period term is caught.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_LE_SETUP,
    ST_LATCH
  } ser_state_e;

  // Smallest whole number of clock cycles covering min_ps; never below one.
  function automatic int unsigned cycles_for(input int unsigned min_ps,
                                             input int unsigned clk_ps);
    int unsigned c;
    c = (min_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Low phase must cover the low minimum, the data setup and what the period
  // still needs after the high phase.
  function automatic int unsigned low_phase(input int unsigned low_c,
                                            input int unsigned setup_c,
                                            input int unsigned period_c,
                                            input int unsigned high_c);
    int unsigned rest;
    rest = (period_c > high_c) ? (period_c - high_c) : 1;
    return max2(max2(low_c, setup_c), rest);
  endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val - 1'b1;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // Phase timing relies on the count moving down every idle cycle.
  assert_timer_descends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !done) |=> (cnt < $past(cnt)));

endmodule

// File: rtl/bit_shifter.sv
module bit_shifter #(
  parameter int unsigned WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [WORD_W-1:0] word_in,
  input  logic              shift,
  output logic              msb_out,
  output logic              last_bit
);

  localparam int unsigned LEFT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh;
  logic [LEFT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (capture) begin
      sh   <= word_in;
      left <= LEFT_W'(WORD_W - 1);
    end else if (shift) begin
      sh   <= {sh[WORD_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign msb_out  = sh[WORD_W-1];
  assign last_bit = (left == '0);

  // Never shift beyond the last bit of the word.
  assert_shift_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !last_bit);

endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
  import atten_ser_pkg::*;
#(
  parameter int unsigned WORD_W        = 6,
  parameter int unsigned CLK_PS        = 8000,
  parameter int unsigned HIGH_MIN_PS   = 30000,
  parameter int unsigned LOW_MIN_PS    = 30000,
  parameter int unsigned SETUP_MIN_PS  = 10000,
  parameter int unsigned HOLD_MIN_PS   = 10000,
  parameter int unsigned LESU_MIN_PS   = 10000,
  parameter int unsigned LEW_MIN_PS    = 30000,
  parameter int unsigned PERIOD_MIN_PS = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              ready,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_latch
);

  localparam int unsigned HIGH_C   = cycles_for(HIGH_MIN_PS, CLK_PS);
  localparam int unsigned LOW_C    = cycles_for(LOW_MIN_PS, CLK_PS);
  localparam int unsigned SETUP_C  = cycles_for(SETUP_MIN_PS, CLK_PS);
  localparam int unsigned HOLD_C   = cycles_for(HOLD_MIN_PS, CLK_PS);
  localparam int unsigned LESU_C   = cycles_for(LESU_MIN_PS, CLK_PS);
  localparam int unsigned LEW_C    = cycles_for(LEW_MIN_PS, CLK_PS);
  localparam int unsigned PERIOD_C = cycles_for(PERIOD_MIN_PS, CLK_PS);
  localparam int unsigned HIGH_EFF = max2(HIGH_C, HOLD_C);
  localparam int unsigned LOW_EFF  = low_phase(LOW_C, SETUP_C, PERIOD_C, HIGH_EFF);
  localparam int unsigned MAX_C    = max2(max2(HIGH_EFF, LOW_EFF), max2(LESU_C, LEW_C));
  localparam int unsigned CNT_W    = $clog2(MAX_C + 1);

  ser_state_e       state, nxt;
  logic             phase_end;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             capture;
  logic             shift;
  logic             last_bit;
  logic             msb;

  phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (phase_end)
  );

  bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .word_in  (word),
    .shift    (shift),
    .msb_out  (msb),
    .last_bit (last_bit)
  );

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(LOW_EFF);
    capture  = 1'b0;
    shift    = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        nxt      = ST_LOW;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(LOW_EFF);
        capture  = 1'b1;
      end
      ST_LOW: if (phase_end) begin
        nxt      = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HIGH_EFF);
      end
      ST_HIGH: if (phase_end) begin
        tmr_load = 1'b1;
        if (last_bit) begin
          nxt     = ST_LE_SETUP;
          tmr_val = CNT_W'(LESU_C);
        end else begin
          nxt     = ST_LOW;
          tmr_val = CNT_W'(LOW_EFF);
          shift   = 1'b1;
        end
      end
      ST_LE_SETUP: if (phase_end) begin
        nxt      = ST_LATCH;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(LEW_C);
      end
      ST_LATCH: if (phase_end) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign ready     = (state == ST_IDLE);
  assign ser_clk   = (state == ST_HIGH);
  assign ser_latch = (state == ST_LATCH);
  assign ser_data  = msb;

  assert_data_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  assert_latch_clock_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_latch |-> !ser_clk);

  assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ready && !phase_end) |=> $stable(state));

  assert_idle_lines_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!ser_clk && !ser_latch));

endmodule

// File: tb/atten_serial_master_test.sv
module atten_serial_master_test;

  localparam int CLK_NS  = 8;
  localparam int HI_C    = (30 + CLK_NS - 1) / CLK_NS;
  localparam int LO_C    = (30 + CLK_NS - 1) / CLK_NS;
  localparam int SU_C    = (10 + CLK_NS - 1) / CLK_NS;
  localparam int HO_C    = (10 + CLK_NS - 1) / CLK_NS;
  localparam int LESU_C  = (10 + CLK_NS - 1) / CLK_NS;
  localparam int LEW_C   = (30 + CLK_NS - 1) / CLK_NS;
  localparam int PER_C   = (100 + CLK_NS - 1) / CLK_NS;
  localparam int H_PH    = (HI_C > HO_C) ? HI_C : HO_C;
  localparam int L_A     = (LO_C > SU_C) ? LO_C : SU_C;
  localparam int L_PH    = (L_A > PER_C - H_PH) ? L_A : PER_C - H_PH;
  localparam int TOTAL   = 6 * (H_PH + L_PH) + LESU_C + LEW_C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] word = '0;
  wire        ready, sclk, sdat, sle;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  atten_serial_master uut (
    .clk(clk), .rst_n(rst_n), .start(start), .word(word),
    .ready(ready), .ser_clk(sclk), .ser_data(sdat), .ser_latch(sle)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_word(input logic [5:0] w, input bit poke);
    int n = 0, bits = 0, hi_run = 0, lo_run = 0, le_run = 0;
    int st_run = 1, since_rise = 1000, last_rise = -1;
    logic [5:0] got = '0;
    logic prev_c = 1'b0, prev_l = 1'b0, last_d;
    bit ended = 1'b0;
    @(negedge clk);
    last_d = sdat;
    start = 1'b1;
    word = w;
    @(negedge clk);
    start = 1'b0;
    word = ~w;
    while (n < 2000) begin
      if (ready) begin
        check(n == TOTAL, "R10 busy length", n, TOTAL);
        check(prev_l && !sle, "R7 ready with latch fall", int'(prev_l), 1);
        ended = 1'b1;
        break;
      end
      since_rise++;
      if (sdat !== last_d) begin
        check(!sclk, "R3 data moved with clock high", int'(sclk), 0);
        check(since_rise >= HO_C, "R3 hold", since_rise, HO_C);
      end
      if (sclk && !prev_c) begin
        check(sdat === last_d && st_run >= SU_C, "R3 setup", st_run, SU_C);
        check(lo_run >= LO_C, "R2 low time", lo_run, LO_C);
        if (last_rise >= 0) check(n - last_rise >= PER_C, "R6 period", n - last_rise, PER_C);
        last_rise = n;
        got = {got[4:0], sdat};
        bits++;
        since_rise = 0;
      end
      if (!sclk && prev_c) check(hi_run >= HI_C, "R2 high time", hi_run, HI_C);
      if (sle && !prev_l) begin
        check(!sclk && lo_run >= LESU_C, "R4 latch setup", lo_run, LESU_C);
        check(bits == 6, "R4 latch after all bits", bits, 6);
      end
      if (sle && sclk) check(1'b0, "R4 latch with clock high", 1, 0);
      if (!sle && prev_l) check(le_run >= LEW_C, "R5 latch width", le_run, LEW_C);
      hi_run = sclk ? hi_run + 1 : 0;
      lo_run = sclk ? 0 : lo_run + 1;
      le_run = sle ? le_run + 1 : 0;
      st_run = (sdat === last_d) ? st_run + 1 : 1;
      last_d = sdat;
      prev_c = sclk;
      prev_l = sle;
      if (poke && n == 20) begin start = 1'b1; word = ~w; end
      if (n == 21) start = 1'b0;
      n++;
      @(negedge clk);
    end
    check(ended, "R7 ready returned", int'(ended), 1);
    check(got == w && bits == 6, "R1 word order", int'(got), int'(w));
    if (poke) check(got == w && n == TOTAL, "R8 busy start ignored", n, TOTAL);
    check(!sclk && !sle, "R9 idle lines", int'({sclk, sle}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R9 reset ready", int'(ready), 1);
    check(!sclk && !sle, "R9 reset lines", int'({sclk, sle}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 64; w++) run_word(6'(w), (w % 4) == 1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=timeout expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule